// File: doc/BRIEF.md
# Trimmed Seconds Counter with Cross-Domain Write Tracking

This block keeps a free-running count of whole seconds in a slow clock domain, normally a 32.768 kHz crystal clock, so that time continues to advance whether the host side is busy, idle or in a low-power state. A programmable trim divider sits in front of the counter. The count advances once every trim+1 slow-clock cycles, so a trim of 32767 gives one increment per second.

A host in a separate fast clock domain programs the block through a small word-addressed register port. Writes to the trim divider and loads of a new count are handed across to the slow domain with toggle handshakes. Each of these two write paths has its own busy flag, which stays set until the slow domain has taken the value up. While a flag is set, a further write to the same register is dropped. The host reads the running count through a handshake snapshot, so a 32-bit value is never torn. A status word also reports the enable setting and whether slow-clock edges are arriving.

Top module: `tod_seconds_counter`

## Requirements
- R1: After reset, the status word (address 0), the trim value (address 1) and the count (address 2) all read as zero.
- R2: Address 0 is the status word. Bit 0 is the counter enable and is read/write. Bit 1 is slow-clock-present. Bit 2 is count-load busy. Bit 3 is trim busy. The remaining bits read zero. Address 1 reads back and writes the trim value. Address 2 reads the count, and a write to it loads a new count. A write is accepted on a host clock edge where wrEn is high.
- R3: While the counter is enabled, the count advances by exactly one for every trim+1 slow-clock cycles.
- R4: An accepted count load sets the count-load busy bit from the next host cycle. The bit clears only after the slow domain has loaded the value.
- R5: A count load that is written while count-load busy is set is discarded.
- R6: An accepted trim write sets the trim busy bit. A trim write made while that bit is set is discarded.
- R7: A loaded count becomes visible after the load completes. The divider phase restarts at zero on the slow edge that performs the load.
- R8: While the enable bit is clear, the count holds its value.
- R9: The count uses the full unsigned 32-bit range and wraps from all ones to zero.
- R10: Slow-clock-present is set once a slow-clock edge is seen. It clears when no edge arrives within DETECT_WINDOW host cycles.
- R11: The count read by the host is a coherent snapshot. While the counter runs, successive reads never decrease, apart from a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostClk | input | 1 | Fast host clock |
| slowClk | input | 1 | Slow counting clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wrData | input | CNT_W | Register write data |
| rdData | output | CNT_W | Register read data, selected combinationally by addr |

## Verification
Assertions check several properties on every cycle:
- A busy flag rises only on an accepted write.
- Held write values stay stable while their busy flag is set.
- A load strobe places the held value into the count.
- The count freezes while the counter is disabled.
- The published snapshot does not change while a handshake is open.

Only the bench scenarios can show the end-to-end effects:
- The exact divide ratio.
- The restart of the divider phase after a load.
- The wrap at the top of the range.
- Writes being dropped while busy.
- The present bit falling when the slow clock stops.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_TRIM   = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;

  // slow-domain strobes from control to datapath
  typedef struct packed {
    logic loadCount;
    logic loadTrim;
    logic run;
    logic publish;
  } todStrobe_t;
endpackage

// File: rtl/tod_clk_detect.sv
module tod_clk_detect #(
  parameter int WINDOW = 8192
) (
  input  logic hostClk,
  input  logic rstN,
  input  logic slowClk,
  output logic clkOk
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [2:0]    slowSync;
  logic [CW-1:0] idleCnt;
  logic          slowEdge;

  assign slowEdge = slowSync[1] & ~slowSync[2];

  always_ff @(posedge hostClk or negedge rstN) begin
    if (!rstN) begin
      slowSync <= '0;
      idleCnt  <= '0;
      clkOk    <= 1'b0;
    end else begin
      slowSync <= {slowSync[1:0], slowClk};
      if (slowEdge) begin
        idleCnt <= '0;
        clkOk   <= 1'b1;
      end else if (idleCnt == CW'(WINDOW - 1)) begin
        clkOk <= 1'b0;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  // R10
  clk_ok_rise_chk: assert property (@(posedge hostClk) disable iff (!rstN)
    $rose(clkOk) |-> $past(slowEdge));
endmodule

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TRIM_W = 16
) (
  input  logic              hostClk,
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  pubCount,
  output logic [CNT_W-1:0]  loadHold,
  output logic [TRIM_W-1:0] trimHold,
  output logic [CNT_W-1:0]  hostCount,
  output logic              enable,
  output logic              cntBusy,
  output logic              trimBusy,
  output todStrobe_t        strobe
);
  // host domain
  logic       cntReqT, trimReqT, hostAck;
  logic [1:0] cntAckS, trimAckS, pubReqS;
  // slow domain
  logic [1:0] cntReqS, trimReqS, enS, pubAckS;
  logic       cntSeen, trimSeen, pubReq;

  assign cntBusy  = cntReqT ^ cntAckS[1];
  assign trimBusy = trimReqT ^ trimAckS[1];

  always_ff @(posedge hostClk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      loadHold  <= '0;
      trimHold  <= '0;
      cntReqT   <= 1'b0;
      trimReqT  <= 1'b0;
      cntAckS   <= '0;
      trimAckS  <= '0;
      pubReqS   <= '0;
      hostAck   <= 1'b0;
      hostCount <= '0;
    end else begin
      cntAckS  <= {cntAckS[0], cntSeen};
      trimAckS <= {trimAckS[0], trimSeen};
      pubReqS  <= {pubReqS[0], pubReq};
      if (pubReqS[1] != hostAck) begin
        hostCount <= pubCount;
        hostAck   <= pubReqS[1];
      end
      if (wrEn) begin
        case (addr)
          ADDR_STATUS: enable <= wrData[0];
          ADDR_TRIM: if (!trimBusy) begin
            trimHold <= wrData[TRIM_W-1:0];
            trimReqT <= ~trimReqT;
          end
          ADDR_COUNT: if (!cntBusy) begin
            loadHold <= wrData;
            cntReqT  <= ~cntReqT;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.loadCount = cntReqS[1] ^ cntSeen;
    strobe.loadTrim  = trimReqS[1] ^ trimSeen;
    strobe.run       = enS[1];
    strobe.publish   = (pubReq == pubAckS[1]);
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      cntReqS  <= '0;
      trimReqS <= '0;
      enS      <= '0;
      pubAckS  <= '0;
      cntSeen  <= 1'b0;
      trimSeen <= 1'b0;
      pubReq   <= 1'b0;
    end else begin
      cntReqS  <= {cntReqS[0], cntReqT};
      trimReqS <= {trimReqS[0], trimReqT};
      enS      <= {enS[0], enable};
      pubAckS  <= {pubAckS[0], hostAck};
      cntSeen  <= cntReqS[1];
      trimSeen <= trimReqS[1];
      if (strobe.publish) pubReq <= ~pubReq;
    end
  end

  // R4
  cnt_busy_rise_chk: assert property (@(posedge hostClk) disable iff (!rstN)
    $rose(cntBusy) |-> $past(wrEn && addr == ADDR_COUNT));
  // R5
  load_hold_stable_chk: assert property (@(posedge hostClk) disable iff (!rstN)
    (cntBusy && $past(cntBusy)) |-> $stable(loadHold));
  // R6
  trim_hold_stable_chk: assert property (@(posedge hostClk) disable iff (!rstN)
    (trimBusy && $past(trimBusy)) |-> $stable(trimHold));
  // R11
  snapshot_stable_chk: assert property (@(posedge slowClk) disable iff (!rstN)
    (pubReq != pubAckS[1]) |=> $stable(pubCount));
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TRIM_W = 16
) (
  input  logic              slowClk,
  input  logic              rstN,
  input  todStrobe_t        strobe,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic [TRIM_W-1:0] trimVal,
  output logic [CNT_W-1:0]  pubCount
);
  logic [CNT_W-1:0]  count;
  logic [TRIM_W-1:0] phase, trimReg;

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      phase    <= '0;
      trimReg  <= '0;
      pubCount <= '0;
    end else begin
      if (strobe.loadTrim) trimReg <= trimVal;
      if (strobe.loadCount) begin
        count <= loadVal;
        phase <= '0;
      end else if (strobe.run) begin
        if (phase >= trimReg) begin
          phase <= '0;
          count <= count + 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
      if (strobe.publish) pubCount <= count;
    end
  end

  // R7
  load_takes_value_chk: assert property (@(posedge slowClk) disable iff (!rstN)
    strobe.loadCount |=> (count == $past(loadVal)));
  // R8
  hold_when_off_chk: assert property (@(posedge slowClk) disable iff (!rstN)
    (!strobe.run && !strobe.loadCount) |=> $stable(count));
endmodule

// File: rtl/tod_seconds_counter.sv
module tod_seconds_counter
  import tod_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int TRIM_W        = 16,
  parameter int DETECT_WINDOW = 8192
) (
  input  logic             hostClk,
  input  logic             slowClk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData
);
  todStrobe_t        strobe;
  logic [CNT_W-1:0]  loadHold, pubCount, hostCount;
  logic [TRIM_W-1:0] trimHold;
  logic              enable, cntBusy, trimBusy, clkOk;

  tod_ctrl #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_ctrl (
    .hostClk(hostClk), .slowClk(slowClk), .rstN(rstN),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .pubCount(pubCount),
    .loadHold(loadHold), .trimHold(trimHold), .hostCount(hostCount),
    .enable(enable), .cntBusy(cntBusy), .trimBusy(trimBusy), .strobe(strobe)
  );

  tod_datapath #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_dp (
    .slowClk(slowClk), .rstN(rstN), .strobe(strobe),
    .loadVal(loadHold), .trimVal(trimHold), .pubCount(pubCount)
  );

  tod_clk_detect #(.WINDOW(DETECT_WINDOW)) u_det (
    .hostClk(hostClk), .rstN(rstN), .slowClk(slowClk), .clkOk(clkOk)
  );

  always_comb begin
    case (addr)
      ADDR_STATUS: rdData = {{(CNT_W-4){1'b0}}, trimBusy, cntBusy, clkOk, enable};
      ADDR_TRIM:   rdData = {{(CNT_W-TRIM_W){1'b0}}, trimHold};
      ADDR_COUNT:  rdData = hostCount;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: tb/test_tod_seconds_counter.sv
`timescale 1ns/1ps
module test_tod_seconds_counter;
  logic        hostClk = 0, slowClk = 0, rstN = 0, wrEn = 0, slowRun = 1;
  logic [1:0]  addr = 0;
  logic [31:0] wrData = 0, rdData;
  int checks = 0, errors = 0;

  tod_seconds_counter #(.DETECT_WINDOW(64)) i_tod_seconds_counter (
    .hostClk(hostClk), .slowClk(slowClk), .rstN(rstN), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData));

  always #4 hostClk = ~hostClk;
  always begin #68; if (slowRun) slowClk = ~slowClk; end

  function automatic logic [31:0] statusWord(bit en, bit ok, bit cb, bit tb);
    return {28'd0, tb, cb, ok, en};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [1:0] a, logic [31:0] d);
    @(negedge hostClk); wrEn = 1; addr = a; wrData = d;
    @(negedge hostClk); wrEn = 0;
  endtask

  task automatic readReg(logic [1:0] a, output logic [31:0] v);
    @(negedge hostClk); addr = a; #1 v = rdData;
  endtask

  task automatic waitSlow(int n);
    repeat (n) @(posedge slowClk);
  endtask

  task automatic waitClear(int bitIdx, string req);
    logic [31:0] s;
    int n = 0;
    do begin readReg(0, s); n++; end while (s[bitIdx] && n < 3000);
    check(!s[bitIdx], req, s, s & ~(32'd1 << bitIdx));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin @(posedge hostClk); cyc++; end
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, x, y, z, c1, c2;
    void'($urandom(32'h1234abcd));
    repeat (5) @(negedge hostClk);
    readReg(0, v); check(v == 0, "R1 status", v, 0);
    readReg(1, v); check(v == 0, "R1 trim", v, 0);
    readReg(2, v); check(v == 0, "R1 count", v, 0);
    rstN = 1;
    waitSlow(10);
    readReg(0, v); check(v == statusWord(0, 1, 0, 0), "R10 present", v, statusWord(0, 1, 0, 0));

    // R6: trim busy and ignored second write
    writeReg(1, 15);
    readReg(0, v); check(v[3], "R6 trim busy", v, statusWord(0, 1, 0, 1));
    writeReg(1, 9);
    waitClear(3, "R6 trim busy clears");
    readReg(1, v); check(v == 15, "R6 trim kept", v, 15);

    // R4/R5/R8: loads with enable off
    x = $urandom; y = ~x;
    writeReg(2, x);
    readReg(0, v); check(v[2], "R4 load busy", v, statusWord(0, 1, 1, 0));
    writeReg(2, y);
    waitClear(2, "R4 load busy clears");
    waitSlow(10);
    readReg(2, v); check(v == x, "R5 second load dropped", v, x);
    waitSlow(30);
    readReg(2, v); check(v == x, "R8 hold while disabled", v, x);

    // R2/R7/R3: enable, load, phase restart with trim 15
    writeReg(0, 1);
    readReg(0, v); check(v == statusWord(1, 1, 0, 0), "R2 enable bit", v, statusWord(1, 1, 0, 0));
    z = $urandom;
    writeReg(2, z);
    waitClear(2, "R4 load busy clears");
    waitSlow(10);
    readReg(2, v); check(v == z, "R7 load visible", v, z);
    waitSlow(20);
    readReg(2, v); check(v == z + 1, "R3 one tick per trim+1", v, z + 1);

    // R3/R11 random rate checks
    for (int i = 0; i < 6; i++) begin
      int t = 5 + ($urandom % 4);
      int k = 3 + ($urandom % 3);
      writeReg(1, t);
      waitClear(3, "R6 trim busy clears");
      waitSlow(2 * (t + 1));
      readReg(2, c1);
      waitSlow(k * (t + 1));
      readReg(2, c2);
      check((c2 - c1 >= k - 1) && (c2 - c1 <= k + 1), "R3 rate", c2 - c1, k);
      check(c2 >= c1, "R11 monotonic", c2, c1);
    end

    // R9 wrap
    writeReg(1, 0);
    waitClear(3, "R6 trim busy clears");
    writeReg(2, 32'hFFFF_FFFD);
    waitClear(2, "R4 load busy clears");
    waitSlow(10);
    readReg(2, v); check(v < 16, "R9 wrap", v, 32'd7);

    // R10 clock loss and return
    slowRun = 0;
    repeat (200) @(negedge hostClk);
    readReg(0, v); check(!v[1], "R10 clock lost", v, statusWord(1, 0, 0, 0));
    slowRun = 1;
    waitSlow(3);
    readReg(0, v); check(v[1], "R10 clock back", v, statusWord(1, 1, 0, 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule